// File: doc/BRIEF.md
# Masked Binary Flood-Fill Cell Array

This block is a square grid of one-bit cells. Each cell is wired only to the cells directly above, below, left and right of it. A binary wave starts at chosen seed cells and spreads outward, one hop per clock. It can only pass through cells whose marker bit is set, so the marker map defines the region the wave may fill.

Each cell also has a four-bit accept mask. The mask chooses which of its neighbours the cell will take the wave from. This lets the wave follow only the permitted directions, for example accepting the wave only from the lowest neighbours when flooding a basin.

A run is used as follows:

1. Apply the marker map, the seed map and the masks.
2. Pulse start.
3. Wait for done.

When the wave stops growing, the final state of every cell is copied into a result bit. That result bit can then serve as a per-cell condition flag. A clear pulse removes all wave activity before a new run. Regions can be flooded one at a time by clearing between runs. If the clear is left out, each new run adds to the region already reached.

Top module: `wave_flood_array`

## Requirements
- R1: After reset, `result_o` is all zeros and `done_o` is 0.
- R2: A seed cell becomes active on the start edge only if its marker bit is 1. A seed whose marker is 0 never reaches the result.
- R3: The wave spreads one hop per clock. It moves only between orthogonal neighbours whose markers are 1, never diagonally, and it fills every marked cell connected to any seed.
- R4: A cell with marker 0 never becomes active, so the wave cannot cross it.
- R5: Cell index is row*SIDE+col. The accept field of cell i is `accept_i[4i+3:4i]`. In that field, bit 0 accepts the wave from the row above, bit 1 from the column to the right, bit 2 from the row below, and bit 3 from the column to the left. A cleared bit ignores that neighbour.
- R6: Neighbours outside the grid count as inactive. The last cell of one row is not a neighbour of the first cell of the next row, and the top and bottom rows do not wrap.
- R7: The first clock edge after start at which no cell changes sets `done_o` and copies all activity into `result_o`. For a straight path of length L cells from a single seed, `done_o` is 0 after L clock edges counted from the start edge and 1 after L+1.
- R8: `clr_i` clears all activity and `done_o` but leaves `result_o` unchanged. If `clr_i` and `start_i` are high together, the clear wins and no run begins.
- R9: Activity only rises during a run. A new start without a clear keeps cells that were already active, so the result is the union of both regions.
- R10: A start with no valid seed sets `done_o` on the second clock edge counted from the start edge, and the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clears all activity and done |
| start_i | input | 1 | Start pulse; injects the seeds |
| mark_i | input | SIDE*SIDE | Marker map; 1 = cell may carry the wave |
| seed_i | input | SIDE*SIDE | Seed map |
| accept_i | input | 4*SIDE*SIDE | Per-cell direction accept masks |
| result_o | output | SIDE*SIDE | Captured reached-state map |
| done_o | output | 1 | Wave has settled; result is valid |

## Verification
The bench builds the array with SIDE=4. That gives 16 cells: four corners, edge cells, and interior cells with all four neighbours. At this size the row-end and top/bottom non-wrap cases can be checked with maps written out in the bench. It is also large enough for a four-cell straight path whose done latency is checked edge by edge, and for a two-region union and single-direction mask flows along a full row and a full column.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int DIRS  = 4;
  localparam int DIR_N = 0;
  localparam int DIR_E = 1;
  localparam int DIR_S = 2;
  localparam int DIR_W = 3;
endpackage

// File: rtl/wf_cell.sv
module wf_cell
  import wf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic            cap_i,
  input  logic            start_i,
  input  logic            mark_i,
  input  logic            seed_i,
  input  logic [DIRS-1:0] acc_i,
  input  logic [DIRS-1:0] nbr_i,
  output logic            act_o,
  output logic            chg_o,
  output logic            res_o
);
  logic act_q, act_d, res_q, res_d, wake;

  always_comb begin
    wake  = mark_i & ((start_i & seed_i) | (|(acc_i & nbr_i)));
    chg_o = en_i & wake & ~act_q;
    act_d = act_q;
    if (clr_i)           act_d = 1'b0;
    else if (en_i & wake) act_d = 1'b1;
    res_d = res_q;
    if (cap_i) res_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      res_q <= 1'b0;
    end else begin
      act_q <= act_d;
      res_q <= res_d;
    end
  end

  assign act_o = act_q;
  assign res_o = res_q;

  assert_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !clr_i) |=> act_q);
  assert_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mark_i && !act_q) |=> !act_q);
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (res_q == $past(act_q)));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !act_q);
endmodule

// File: rtl/wf_ctrl.sv
module wf_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic start_i,
  input  logic any_chg_i,
  output logic en_o,
  output logic cap_o,
  output logic done_o
);
  logic run_q, run_d, done_q, done_d, settle;

  always_comb begin
    settle = run_q & ~start_i & ~clr_i & ~any_chg_i;
    en_o   = (run_q | start_i) & ~clr_i;
    cap_o  = settle;
    run_d  = run_q;
    done_d = done_q;
    if (clr_i) begin
      run_d  = 1'b0;
      done_d = 1'b0;
    end else if (start_i) begin
      run_d  = 1'b1;
      done_d = 1'b0;
    end else if (settle) begin
      run_d  = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run_q);
  assert_clr_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!done_q && !run_q));
  assert_start_clears_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clr_i) |=> (run_q && !done_q));
  assert_change_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && any_chg_i && !clr_i) |=> !done_q);
endmodule

// File: rtl/wave_flood_array.sv
module wave_flood_array
  import wf_pkg::*;
#(
  parameter int SIDE = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    start_i,
  input  logic [SIDE*SIDE-1:0]    mark_i,
  input  logic [SIDE*SIDE-1:0]    seed_i,
  input  logic [DIRS*SIDE*SIDE-1:0] accept_i,
  output logic [SIDE*SIDE-1:0]    result_o,
  output logic                    done_o
);
  localparam int CELLS = SIDE * SIDE;

  logic [CELLS-1:0]      act_w;
  logic [CELLS-1:0]      chg_w;
  logic [DIRS*CELLS-1:0] nbr_w;
  logic                  en_w, cap_w;

  for (genvar r = 0; r < SIDE; r++) begin : g_row
    for (genvar c = 0; c < SIDE; c++) begin : g_col
      localparam int IDX = r * SIDE + c;
      if (r > 0) begin : g_n
        assign nbr_w[IDX*DIRS+DIR_N] = act_w[IDX-SIDE];
      end else begin : g_n0
        assign nbr_w[IDX*DIRS+DIR_N] = 1'b0;
      end
      if (c < SIDE-1) begin : g_e
        assign nbr_w[IDX*DIRS+DIR_E] = act_w[IDX+1];
      end else begin : g_e0
        assign nbr_w[IDX*DIRS+DIR_E] = 1'b0;
      end
      if (r < SIDE-1) begin : g_s
        assign nbr_w[IDX*DIRS+DIR_S] = act_w[IDX+SIDE];
      end else begin : g_s0
        assign nbr_w[IDX*DIRS+DIR_S] = 1'b0;
      end
      if (c > 0) begin : g_w
        assign nbr_w[IDX*DIRS+DIR_W] = act_w[IDX-1];
      end else begin : g_w0
        assign nbr_w[IDX*DIRS+DIR_W] = 1'b0;
      end

      wf_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .en_i    (en_w),
        .cap_i   (cap_w),
        .start_i (start_i),
        .mark_i  (mark_i[IDX]),
        .seed_i  (seed_i[IDX]),
        .acc_i   (accept_i[IDX*DIRS +: DIRS]),
        .nbr_i   (nbr_w[IDX*DIRS +: DIRS]),
        .act_o   (act_w[IDX]),
        .chg_o   (chg_w[IDX]),
        .res_o   (result_o[IDX])
      );
    end
  end

  wf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .start_i   (start_i),
    .any_chg_i (|chg_w),
    .en_o      (en_w),
    .cap_o     (cap_w),
    .done_o    (done_o)
  );

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_w |=> (result_o == $past(result_o)));
endmodule

// File: tb/wave_flood_array_tb_top.sv
module wave_flood_array_tb_top;
  localparam int SIDE  = 4;
  localparam int CELLS = 16;
  localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

  // {marker, seed, accept, expected result}
  localparam logic [111:0] VEC [8] = '{
    {16'hFFFF, 16'h0001, ALL, 16'hFFFF},                   // R3 full fill
    {16'h898F, 16'h0001, ALL, 16'h888F},                   // R4 blocked island
    {16'h0021, 16'h0001, ALL, 16'h0001},                   // R3 no diagonal
    {16'h1019, 16'h0008, ALL, 16'h0008},                   // R6 no wrap
    {16'h00F0, 16'h0001, ALL, 16'h0000},                   // R2 seed on marker 0
    {16'hFFFF, 16'h0001, 64'h8888_8888_8888_8888, 16'h000F}, // R5 from-left only
    {16'hFFFF, 16'h0001, 64'h1111_1111_1111_1111, 16'h1111}, // R5 from-above only
    {16'hFF0F, 16'h8001, ALL, 16'hFF0F}                    // R3 two seeds
  };

  logic clk = 1'b0;
  logic rst_n, clr, start;
  logic [CELLS-1:0] mark, seed, result;
  logic [4*CELLS-1:0] acc;
  logic done;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  wave_flood_array #(.SIDE(SIDE)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .start_i(start),
    .mark_i(mark), .seed_i(seed), .accept_i(acc),
    .result_o(result), .done_o(done)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; start = 1'b0;
    mark = '0; seed = '0; acc = ALL;
    repeat (3) @(negedge clk);
    chk(result == 16'h0 && done == 1'b0, "R1 reset", {result, 15'b0, done}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      pulse_clr();
      mark = VEC[v][111:96];
      seed = VEC[v][95:80];
      acc  = VEC[v][79:16];
      pulse_start();
      wait_done();
      chk(done, "R7 done in vector", done, 1);
      chk(result == VEC[v][15:0], $sformatf("R3/R4/R5/R6/R2 vector %0d", v), result, VEC[v][15:0]);
    end

    // R7 latency: straight four-cell path along row 0
    pulse_clr();
    acc = ALL; mark = 16'h000F; seed = 16'h0001;
    pulse_start();
    chk(!done, "R7 done cleared by start", done, 0);
    repeat (3) @(negedge clk);
    chk(!done, "R7 not done after L edges", done, 0);
    @(negedge clk);
    chk(done, "R7 done after L+1 edges", done, 1);
    chk(result == 16'h000F, "R7 result captured", result, 16'h000F);

    // R8 clear keeps result, drops done
    pulse_clr();
    chk(!done && result == 16'h000F, "R8 clear keeps result", {result, 15'b0, done}, {16'h000F, 16'h0});

    // R8 clear wins over start
    mark = 16'hFFFF; seed = 16'h0001;
    @(negedge clk) begin clr = 1'b1; start = 1'b1; end
    @(negedge clk) begin clr = 1'b0; start = 1'b0; end
    repeat (12) @(negedge clk);
    chk(!done, "R8 clear beats start: no done", done, 0);
    chk(result == 16'h000F, "R8 clear beats start: result unchanged", result, 16'h000F);

    // R9 union of regions without clear
    pulse_clr();
    mark = 16'hF00F; seed = 16'h0001;
    pulse_start(); wait_done();
    chk(result == 16'h000F, "R9 first region", result, 16'h000F);
    seed = 16'h8000;
    pulse_start(); wait_done();
    chk(result == 16'hF00F, "R9 union after second start", result, 16'hF00F);
    mark = 16'h0000; seed = 16'h0000;
    pulse_start(); wait_done();
    chk(result == 16'hF00F, "R9 activity held when marker drops", result, 16'hF00F);

    // R10 empty start
    pulse_clr();
    mark = 16'hFFFF; seed = 16'h0000;
    pulse_start();
    chk(!done, "R10 not done after start edge", done, 0);
    @(negedge clk);
    chk(done, "R10 done on second edge", done, 1);
    chk(result == 16'h0, "R10 empty result", result, 0);

    finish_run();
  end
endmodule